// File: doc/BRIEF.md
# Two-Level Latched Interrupt Aggregator

The block gathers a group of level-signalled serial interrupt lines into a single interrupt output through two cascaded latch-and-mask stages. The first stage is a host-side bank with three registers: an enable/control register, a mask and a sticky status register. An active level on serial line n latches status bit (31 − n). The masked status, gated by the control register's enable bit, becomes one input bit of a second, outer bank. That bank holds its own mask, a sticky status, a polarity register and a read-only image of its inputs. Its status feeds the single output line.

Software reaches both banks through one 32-bit register port. Writes take effect on the clock edge. Reads are combinational from the current register state. Both status registers are cleared by writing ones. A line that has dropped never clears a bit, so software must acknowledge each source. All evaluation runs on every clock. The outer status therefore picks up a new host-side request one clock after the request appears.

Top module: `irq_cascade_agg`

## Requirements
- R1: After reset every register reads zero and `irq_out` is low.
- R2: A high level on serial line n at a clock edge sets host status bit (31 − n) at offset 0x38, so lines 0..16 occupy bits 31..15. A low level never clears a bit.
- R3: Writing offset 0x38 clears the status bits that are one in the written word and keeps the others. A line that is high in the same cycle keeps its bit set, because the latch wins over the clear.
- R4: Bit 11 of the input image at offset 0x5C is one exactly when control bit 31 (offset 0x30) is set and host status AND host mask (offset 0x34) is nonzero. All other image bits read zero.
- R5: On every clock, the outer status at offset 0x50 ORs in the input image AND the outer mask at offset 0x54. A set bit stays set after its input drops.
- R6: Writing offset 0x50 clears the outer status bits that are one in the written word. An input that is still active and unmasked relatches its bit in the same cycle.
- R7: `irq_out` is high whenever the outer status is nonzero. It rises one clock after the masked input image becomes nonzero.
- R8: The polarity register at offset 0x58 reads back what was written and has no effect on `irq_out`.
- R9: Writes to offset 0x5C are ignored. Reads of any offset other than 0x30, 0x34, 0x38, 0x50, 0x54, 0x58 and 0x5C return all ones.
- R10: The control register (0x30) and both masks (0x34, 0x54) read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Read data for `rd_addr` |
| ser_irq | input | 17 | Serial interrupt line levels, line n at bit n |
| irq_out | output | 1 | Aggregated interrupt output |

## Verification
The risky overlap is a source latching into a status bit in the same cycle that software writes a one to clear it. The bench provokes this on the host bank by holding a serial line high during the clearing write, and expects the bit to survive. It then clears the bit again with the line low and expects the bit to be gone. On the outer bank, the bench clears the status while the host request is still pending and, separately, after the request has been withdrawn. It judges the status readback and `irq_out` on the cycle that follows each clearing write.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

   localparam logic [7:0] OFS_SER_CTRL = 8'h30;
   localparam logic [7:0] OFS_HC_MASK  = 8'h34;
   localparam logic [7:0] OFS_HC_STAT  = 8'h38;
   localparam logic [7:0] OFS_OB_STAT  = 8'h50;
   localparam logic [7:0] OFS_OB_MASK  = 8'h54;
   localparam logic [7:0] OFS_OB_POL   = 8'h58;
   localparam logic [7:0] OFS_OB_INPUT = 8'h5C;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_SER_CTRL,
      SEL_HC_MASK,
      SEL_HC_STAT,
      SEL_OB_STAT,
      SEL_OB_MASK,
      SEL_OB_POL,
      SEL_OB_INPUT
   } reg_sel_e;

   function automatic reg_sel_e decode_ofs(input logic [7:0] ofs);
      case (ofs)
         OFS_SER_CTRL: decode_ofs = SEL_SER_CTRL;
         OFS_HC_MASK:  decode_ofs = SEL_HC_MASK;
         OFS_HC_STAT:  decode_ofs = SEL_HC_STAT;
         OFS_OB_STAT:  decode_ofs = SEL_OB_STAT;
         OFS_OB_MASK:  decode_ofs = SEL_OB_MASK;
         OFS_OB_POL:   decode_ofs = SEL_OB_POL;
         OFS_OB_INPUT: decode_ofs = SEL_OB_INPUT;
         default:      decode_ofs = SEL_NONE;
      endcase
   endfunction

endpackage

// File: rtl/irq_line_map.sv
// Places serial line i at vector bit (TOP_BIT - i); all other bits are zero.
module irq_line_map #(
   parameter int NUM_LINES = 17,
   parameter int DATA_W    = 32,
   parameter int TOP_BIT   = 31
) (
   input  logic [NUM_LINES-1:0] lines,
   output logic [DATA_W-1:0]    vec
);
   localparam int LOW_BIT = TOP_BIT - NUM_LINES + 1;

   if (LOW_BIT < 0 || TOP_BIT >= DATA_W) begin : g_bad_range
      $error("irq_line_map: lines do not fit the vector");
   end

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      if (b >= LOW_BIT && b <= TOP_BIT) begin : g_line
         assign vec[b] = lines[TOP_BIT-b];
      end else begin : g_zero
         assign vec[b] = 1'b0;
      end
   end

endmodule

// File: rtl/irq_sticky_stage.sv
// Sticky status register: set bits latch, write-one clears, set wins.
module irq_sticky_stage #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_vec,
   input  logic         clr_en,
   input  logic [W-1:0] clr_vec,
   output logic [W-1:0] stat
);
   logic [W-1:0] clr_mask;

   assign clr_mask = clr_en ? clr_vec : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) stat <= '0;
      else        stat <= (stat & ~clr_mask) | set_vec;
   end

   // R5: without a clearing write no set bit is lost
   a_r5_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_en) |=> ((stat & $past(stat)) == $past(stat)));

   // R2: every requested bit is present one edge later
   a_r2_latch_set: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec != '0) |=> ((stat & $past(set_vec)) == $past(set_vec)));

   // R6: cleared bits with no concurrent set are gone one edge later
   a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en |=> ((stat & $past(clr_vec) & ~$past(set_vec)) == '0));

endmodule

// File: rtl/irq_cascade_agg.sv
module irq_cascade_agg
   import irq_agg_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 8,
   parameter int NUM_SER     = 17,
   parameter int CASCADE_BIT = 11,
   parameter int GATE_BIT    = 31
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [DATA_W-1:0]  rd_data,
   input  logic [NUM_SER-1:0] ser_irq,
   output logic               irq_out
);
   localparam int SER_TOP = DATA_W - 1;

   if (ADDR_W != 8) begin : g_bad_addr
      $error("irq_cascade_agg: ADDR_W must be 8");
   end
   if (NUM_SER < 1 || NUM_SER > DATA_W) begin : g_bad_ser
      $error("irq_cascade_agg: NUM_SER out of range");
   end
   if (CASCADE_BIT >= DATA_W || GATE_BIT >= DATA_W) begin : g_bad_bits
      $error("irq_cascade_agg: bit index out of range");
   end

   reg_sel_e wr_sel, rd_sel;
   assign wr_sel = wr_en ? decode_ofs(wr_addr) : SEL_NONE;
   assign rd_sel = decode_ofs(rd_addr);

   logic [DATA_W-1:0] ser_ctrl_q, hc_mask_q, ob_mask_q, ob_pol_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ser_ctrl_q <= '0;
         hc_mask_q  <= '0;
         ob_mask_q  <= '0;
         ob_pol_q   <= '0;
      end else begin
         if (wr_sel == SEL_SER_CTRL) ser_ctrl_q <= wr_data;
         if (wr_sel == SEL_HC_MASK)  hc_mask_q  <= wr_data;
         if (wr_sel == SEL_OB_MASK)  ob_mask_q  <= wr_data;
         if (wr_sel == SEL_OB_POL)   ob_pol_q   <= wr_data;
      end
   end

   // host bank
   logic [DATA_W-1:0] hc_set, hc_stat;

   irq_line_map #(
      .NUM_LINES (NUM_SER),
      .DATA_W    (DATA_W),
      .TOP_BIT   (SER_TOP)
   ) u_map (
      .lines (ser_irq),
      .vec   (hc_set)
   );

   irq_sticky_stage #(.W(DATA_W)) u_hc_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (hc_set),
      .clr_en  (wr_sel == SEL_HC_STAT),
      .clr_vec (wr_data),
      .stat    (hc_stat)
   );

   logic cascade_req;
   assign cascade_req = ser_ctrl_q[GATE_BIT] && ((hc_stat & hc_mask_q) != '0);

   // outer bank
   logic [DATA_W-1:0] ob_input, ob_stat;

   always_comb begin
      ob_input              = '0;
      ob_input[CASCADE_BIT] = cascade_req;
   end

   irq_sticky_stage #(.W(DATA_W)) u_ob_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (ob_input & ob_mask_q),
      .clr_en  (wr_sel == SEL_OB_STAT),
      .clr_vec (wr_data),
      .stat    (ob_stat)
   );

   assign irq_out = (ob_stat != '0);

   always_comb begin
      case (rd_sel)
         SEL_SER_CTRL: rd_data = ser_ctrl_q;
         SEL_HC_MASK:  rd_data = hc_mask_q;
         SEL_HC_STAT:  rd_data = hc_stat;
         SEL_OB_STAT:  rd_data = ob_stat;
         SEL_OB_MASK:  rd_data = ob_mask_q;
         SEL_OB_POL:   rd_data = ob_pol_q;
         SEL_OB_INPUT: rd_data = ob_input;
         default:      rd_data = '1;
      endcase
   end

   // R7: the output only rises after a masked outer input was present
   a_r7_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_out) |-> $past((ob_input & ob_mask_q) != '0));

   // R4: a cascade request never appears while the enable bit is clear
   a_r4_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
      (!ser_ctrl_q[GATE_BIT]) |-> (ob_input == '0));

endmodule

// File: tb/sim_irq_cascade_agg.sv
module sim_irq_cascade_agg;
   localparam int CLK_P = 10;

   localparam logic [1:0] OP_NOP = 2'd0;
   localparam logic [1:0] OP_WR  = 2'd1;
   localparam logic [1:0] OP_RD  = 2'd2;
   localparam logic [1:0] OP_IRQ = 2'd3;

   typedef struct packed {
      logic [1:0]  op;
      logic [7:0]  addr;
      logic [31:0] data;
      logic [16:0] ser;
      logic [31:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 30;
   localparam vec_t TBL [NV] = '{
      '{OP_RD,  8'h38, 32'h0,        17'h0,     32'h0,        4'd1},  // R1
      '{OP_RD,  8'h50, 32'h0,        17'h0,     32'h0,        4'd1},  // R1
      '{OP_IRQ, 8'h00, 32'h0,        17'h0,     32'h0,        4'd1},  // R1
      '{OP_WR,  8'h34, 32'hFFFF8000, 17'h0,     32'h0,        4'd10}, // R10
      '{OP_RD,  8'h34, 32'h0,        17'h0,     32'hFFFF8000, 4'd10}, // R10
      '{OP_WR,  8'h54, 32'h00000800, 17'h0,     32'h0,        4'd10}, // R10
      '{OP_RD,  8'h54, 32'h0,        17'h0,     32'h00000800, 4'd10}, // R10
      '{OP_NOP, 8'h00, 32'h0,        17'h00001, 32'h0,        4'd2},  // R2 line 0
      '{OP_RD,  8'h38, 32'h0,        17'h0,     32'h80000000, 4'd2},  // R2 kept after drop
      '{OP_RD,  8'h5C, 32'h0,        17'h0,     32'h0,        4'd4},  // R4 gate closed
      '{OP_RD,  8'h50, 32'h0,        17'h0,     32'h0,        4'd4},  // R4
      '{OP_WR,  8'h30, 32'h80000000, 17'h0,     32'h0,        4'd4},  // R4 open gate
      '{OP_RD,  8'h5C, 32'h0,        17'h0,     32'h00000800, 4'd4},  // R4
      '{OP_IRQ, 8'h00, 32'h0,        17'h0,     32'h1,        4'd7},  // R7
      '{OP_RD,  8'h50, 32'h0,        17'h0,     32'h00000800, 4'd5},  // R5
      '{OP_WR,  8'h38, 32'h80000000, 17'h0,     32'h0,        4'd3},  // R3 clear
      '{OP_RD,  8'h5C, 32'h0,        17'h0,     32'h0,        4'd3},  // R3
      '{OP_RD,  8'h50, 32'h0,        17'h0,     32'h00000800, 4'd5},  // R5 sticky
      '{OP_WR,  8'h50, 32'h00000800, 17'h0,     32'h0,        4'd6},  // R6
      '{OP_RD,  8'h50, 32'h0,        17'h0,     32'h0,        4'd6},  // R6
      '{OP_IRQ, 8'h00, 32'h0,        17'h0,     32'h0,        4'd7},  // R7
      '{OP_WR,  8'h58, 32'hFFFFFFFF, 17'h0,     32'h0,        4'd8},  // R8
      '{OP_RD,  8'h58, 32'h0,        17'h0,     32'hFFFFFFFF, 4'd8},  // R8
      '{OP_IRQ, 8'h00, 32'h0,        17'h0,     32'h0,        4'd8},  // R8
      '{OP_WR,  8'h5C, 32'h12345678, 17'h0,     32'h0,        4'd9},  // R9
      '{OP_RD,  8'h5C, 32'h0,        17'h0,     32'h0,        4'd9},  // R9
      '{OP_RD,  8'h10, 32'h0,        17'h0,     32'hFFFFFFFF, 4'd9},  // R9
      '{OP_NOP, 8'h00, 32'h0,        17'h10000, 32'h0,        4'd2},  // R2 line 16
      '{OP_RD,  8'h38, 32'h0,        17'h0,     32'h00008000, 4'd2},  // R2
      '{OP_RD,  8'h30, 32'h0,        17'h0,     32'h80000000, 4'd10}  // R10
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [7:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [16:0] ser_irq = '0;
   logic        irq_out;

   int checks = 0;
   int errors = 0;

   irq_cascade_agg u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .ser_irq (ser_irq),
      .irq_out (irq_out)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %08h expected %08h", tag, got, exp);
      end
   endtask

   task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
      rd_addr = a;
      #1;
      check(tag, rd_data, exp);
   endtask

   initial begin
      #(CLK_P*150000);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         ser_irq = TBL[i].ser;
         wr_en   = (TBL[i].op == OP_WR);
         wr_addr = TBL[i].addr;
         wr_data = TBL[i].data;
         rd_addr = TBL[i].addr;
         #1;
         if (TBL[i].op == OP_RD)
            check($sformatf("R%0d vec %0d", TBL[i].req, i), rd_data, TBL[i].exp);
         else if (TBL[i].op == OP_IRQ)
            check($sformatf("R%0d vec %0d irq", TBL[i].req, i), {31'b0, irq_out}, TBL[i].exp);
         @(posedge clk);
      end
      @(negedge clk);
      wr_en = 1'b0; ser_irq = '0;

      // R6 / R7: clear both banks, output drops
      reg_wr(8'h38, 32'hFFFFFFFF);
      reg_wr(8'h50, 32'hFFFFFFFF);
      rd_chk("R6 outer cleared", 8'h50, 32'h0);
      check("R7 irq low after clear", {31'b0, irq_out}, 32'h0);

      // R7 latency: one-cycle pulse on line 5 (bit 26)
      @(negedge clk);
      ser_irq = 17'h00020;
      @(posedge clk);
      @(negedge clk);
      ser_irq = '0;
      rd_chk("R4 image after latch", 8'h5C, 32'h00000800);
      check("R7 irq not yet", {31'b0, irq_out}, 32'h0);
      @(posedge clk);
      @(negedge clk);
      #1;
      check("R7 irq one cycle later", {31'b0, irq_out}, 32'h1);

      // R3 collision: line 3 (bit 28) high while clearing bit 28
      @(negedge clk);
      ser_irq = 17'h00008;
      wr_en = 1'b1; wr_addr = 8'h38; wr_data = 32'h10000000;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; ser_irq = '0;
      rd_chk("R3 set wins over clear", 8'h38, 32'h14000000);
      reg_wr(8'h38, 32'h10000000);
      rd_chk("R3 clear with line low", 8'h38, 32'h04000000);

      // R6 relatch: outer clear while host request pending
      reg_wr(8'h50, 32'h00000800);
      rd_chk("R6 relatch while pending", 8'h50, 32'h00000800);

      // R4 host mask closes the request, status untouched
      reg_wr(8'h34, 32'h0);
      rd_chk("R4 mask gates image", 8'h5C, 32'h0);
      rd_chk("R4 mask keeps status", 8'h38, 32'h04000000);

      // R1 reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      rd_chk("R1 ctrl after reset", 8'h30, 32'h0);
      rd_chk("R1 host stat after reset", 8'h38, 32'h0);
      rd_chk("R1 outer stat after reset", 8'h50, 32'h0);
      rd_chk("R1 polarity after reset", 8'h58, 32'h0);
      check("R1 irq after reset", {31'b0, irq_out}, 32'h0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule